// File: doc/BRIEF.md
# Divider-Paced Tone Waveform Generator

This block produces an 8-bit code stream for a resistor-ladder DAC that drives a speaker. A 2-bit selector picks silence, a square wave, a rising ramp (sawtooth) or a triangle. The pitch comes from a divider input. It sets how many clock cycles separate two sample ticks. No phase accumulator is used. A reloading down-counter marks each sample tick. A second down-counter, clocked by those ticks, marks the end of a ramp period or of a triangle half-period.

The square wave flips its level on every tick, so one half-period lasts `divider` cycles. The ramp climbs one code per tick and falls back to zero once a full period has elapsed. The triangle climbs and falls one code per tick. An explicit direction register flips at each half-period boundary. When the selector changes, the block restarts from a clean state. Every wave then begins from code 0x00 with the direction set to rising.

Top module: `tone_wavegen`

## Requirements
- R1: While reset is asserted (active-low, asynchronous) `dac_code` is 0x00 and the triangle direction is rising.
- R2: Selector 2'b00 is silence: one clock edge after 2'b00 is present at the input, `dac_code` is 0x00, and it stays there.
- R3: A divider value D of 1 or more places sample ticks D cycles apart, and D = 0 acts as D = 1. The first tick falls on the D-th clock edge after a restart edge.
- R4: Selector 2'b01 is the square wave. The code starts at 0x00 and swaps between 0x00 and 0xFF on each tick, so each level lasts D cycles.
- R5: Selector 2'b10 is the sawtooth. The code rises by one on each tick. On tick number SAW_STEPS (256 by default) the code and the period counter both return to 0, which gives codes 0..255 over and over. The code holds at 0xFF rather than wrapping.
- R6: Selector 2'b11 is the triangle. The code moves by one per tick in the current direction. The direction flips on the tick that ends each run of TRI_STEPS ticks (255 by default), so the code runs 0 up to 0xFF and back down to 0x00 every 510 ticks. It holds at 0xFF and 0x00 rather than wrapping.
- R7: On the first clock edge where the selector differs from its value at the previous edge, the tick counter, the period counter, the code and the direction all reset. After that edge the new wave proceeds as if it had started there.
- R8: Apart from a restart, `dac_code` changes only on a clock edge that carries a sample tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Wave select: 00 silence, 01 square, 10 sawtooth, 11 triangle |
| divider | input | DIV_W | Clock cycles per sample tick (0 is treated as 1) |
| dac_code | output | 8 | Code for the resistor-ladder DAC |

## Verification
Every result is a registered output. If a selector change is applied before clock edge E0, the value seen just after edge Ek is the wave evaluated at floor(k/D) ticks. The first tick shows up after edge E_D, and the restart itself is visible after E0. The driver pushes one expected code for every edge from E1 onward, computed in closed form from the tick count. The monitor pops one expected code at each following falling edge, so every comparison takes place half a cycle after the edge that produced the value.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    WAVE_MUTE   = 2'b00,
    WAVE_SQUARE = 2'b01,
    WAVE_SAW    = 2'b10,
    WAVE_TRI    = 2'b11
  } wave_mode_e;

  localparam int          CODE_W   = 8;
  localparam logic [7:0]  CODE_LOW  = 8'h00;
  localparam logic [7:0]  CODE_HIGH = 8'hFF;

  // Saturating step up: holds at the top code.
  function automatic logic [7:0] code_up(input logic [7:0] c);
    return (c == CODE_HIGH) ? c : c + 8'd1;
  endfunction

  // Saturating step down: holds at the bottom code.
  function automatic logic [7:0] code_down(input logic [7:0] c);
    return (c == CODE_LOW) ? c : c - 8'd1;
  endfunction

  // Square level swap.
  function automatic logic [7:0] code_flip(input logic [7:0] c);
    return (c == CODE_LOW) ? CODE_HIGH : CODE_LOW;
  endfunction

endpackage

// File: rtl/tone_tick_gen.sv
module tone_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] divider,
  output logic             tick
);

  // Reload value: D-1, with D = 0 behaving as D = 1.
  function automatic logic [DIV_W-1:0] reload_of(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= reload_of(divider);
    else if (tick)    cnt_q <= reload_of(divider);
    else              cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/tone_step_count.sv
module tone_step_count
  import tone_pkg::*;
#(
  parameter int SAW_STEPS = 256,
  parameter int TRI_STEPS = 255,
  parameter int STEP_W    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  wave_mode_e mode,
  input  logic       tick,
  output logic       span_end
);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] load_val;

  assign load_val = (mode == WAVE_TRI) ? STEP_W'(TRI_STEPS - 1) : STEP_W'(SAW_STEPS - 1);
  assign span_end = tick && (step_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        step_q <= '0;
    else if (restart)  step_q <= load_val;
    else if (span_end) step_q <= load_val;
    else if (tick)     step_q <= step_q - 1'b1;
  end

endmodule

// File: rtl/tone_shaper.sv
module tone_shaper
  import tone_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  wave_mode_e mode,
  input  logic       tick,
  input  logic       span_end,
  output logic [7:0] code
);

  logic [7:0] code_q;
  logic       rising_q;

  assign code = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= CODE_LOW;
      rising_q <= 1'b1;
    end else if (restart) begin
      code_q   <= CODE_LOW;
      rising_q <= 1'b1;
    end else begin
      unique case (mode)
        WAVE_MUTE:   code_q <= CODE_LOW;
        WAVE_SQUARE: if (tick) code_q <= code_flip(code_q);
        WAVE_SAW:    if (tick) code_q <= span_end ? CODE_LOW : code_up(code_q);
        WAVE_TRI: begin
          if (tick)     code_q   <= rising_q ? code_up(code_q) : code_down(code_q);
          if (span_end) rising_q <= ~rising_q;
        end
        default:     code_q <= CODE_LOW;
      endcase
    end
  end

  // R2: silence drives the low code one edge later
  assert_mute_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WAVE_MUTE) |=> (code_q == CODE_LOW));

  // R4: square only ever shows the two rail codes
  assert_square_rails_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WAVE_SQUARE) |=> (code_q == CODE_LOW || code_q == CODE_HIGH));

  // R5: inside a ramp period the code never drops back to zero
  assert_ramp_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WAVE_SAW && !restart && tick && !span_end) |=> (code_q != CODE_LOW));

  // R6: direction only flips at a half-period boundary
  assert_dir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !span_end) |=> $stable(rising_q));

  // R7: a restart clears the code and sets the direction to rising
  assert_restart_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (code_q == CODE_LOW && rising_q));

  // R8: no tick, no restart -> code holds
  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick) |=> $stable(code_q));

endmodule

// File: rtl/tone_wavegen.sv
module tone_wavegen
  import tone_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int SAW_STEPS = 256,
  parameter int TRI_STEPS = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] divider,
  output logic [7:0]       dac_code
);

  localparam int STEP_MAX = (SAW_STEPS > TRI_STEPS) ? SAW_STEPS : TRI_STEPS;
  localparam int STEP_W   = (STEP_MAX > 2) ? $clog2(STEP_MAX) : 1;

  wave_mode_e mode_now;
  wave_mode_e mode_q;
  logic       restart;
  logic       tick;
  logic       span_end;

  assign mode_now = wave_mode_e'(mode);
  assign restart  = (mode_now != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= WAVE_MUTE;
    else        mode_q <= mode_now;
  end

  tone_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .divider (divider),
    .tick    (tick)
  );

  tone_step_count #(
    .SAW_STEPS (SAW_STEPS),
    .TRI_STEPS (TRI_STEPS),
    .STEP_W    (STEP_W)
  ) u_steps (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .mode     (mode_now),
    .tick     (tick),
    .span_end (span_end)
  );

  tone_shaper u_shape (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .mode     (mode_now),
    .tick     (tick),
    .span_end (span_end),
    .code     (dac_code)
  );

  // R3: the first tick never lands on the restart edge's successor unless D <= 1
  assert_tick_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && divider > 1) |=> !tick);

endmodule

// File: tb/tb_tone_wavegen.sv
module tb_tone_wavegen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic [15:0] divider;
  logic [7:0]  dac_code;

  int vec_cnt  = 0;
  int miss_cnt = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  tone_wavegen dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .divider  (divider),
    .dac_code (dac_code)
  );

  // Closed-form expectation from the tick count since restart.
  function automatic logic [7:0] expect_code(input int m, input int d, input int k);
    int de;
    int n;
    int p;
    de = (d == 0) ? 1 : d;
    n  = k / de;
    case (m)
      1:       return (n % 2 == 1) ? 8'hFF : 8'h00;
      2:       return 8'(n % 256);
      3: begin
        p = n % 510;
        return (p <= 255) ? 8'(p) : 8'(510 - p);
      end
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_now(input logic [7:0] e, input string tag);
    vec_cnt++;
    if (dac_code !== e) begin
      miss_cnt++;
      $display("FAIL %s: dac_code=%h expected %h", tag, dac_code, e);
    end
  endtask

  // Driver: new selector before edge E0, then one expected item per edge.
  task automatic run_case(input int m, input int d, input int n_edges, input string tag);
    @(negedge clk);
    mode    = 2'(m);
    divider = 16'(d);
    @(posedge clk);
    for (int k = 1; k <= n_edges; k++) begin
      @(posedge clk);
      exp_q.push_back(expect_code(m, d, k));
      tag_q.push_back((k == 1) ? {"R7/", tag} : tag);
    end
  endtask

  // Monitor: compares half a cycle after each producing edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_now(e, t);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    miss_cnt++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    mode    = 2'b00;
    divider = 16'd4;
    #3;
    check_now(8'h00, "R1 reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run_case(0, 4, 6, "R2 mute");
    run_case(1, 3, 24, "R4 square D3");
    run_case(2, 1, 600, "R5 ramp wrap");
    run_case(3, 1, 1100, "R6 triangle peak/trough");
    run_case(1, 0, 12, "R3 divider zero");
    run_case(2, 5, 300, "R5 ramp D5");
    run_case(3, 4, 240, "R6 triangle D4");
    run_case(0, 2, 8, "R2 mute after triangle");
    run_case(3, 2, 30, "R8 triangle hold");
    run_case(1, 7, 40, "R8 square hold D7");
    run_case(2, 3, 20, "R3 ramp D3");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

endmodule